// File: doc/BRIEF.md
# Field-Masked Control Register Bank

This block is a bank of sixteen 32-bit control registers for a processor core. Software or a debug path selects a register by a 4-bit index. Reads are combinational. A write is merged bit by bit against two constant masks for that register. The writable mask picks the bits taken from the write data. The read-only mask picks the bits that keep their current value. Every bit outside both masks is reserved: it is stored as zero and always reads as zero. A register with no unreserved bit at all reads as zero whatever is written to it.

Two build options set the masks at elaboration. One selects external (vectored) interrupt support. The other selects virtual-memory support. Without external interrupts, the bank keeps an internal interrupt pair of 32 bits each. The pending word copies the 32 interrupt input levels on every clock, and the enable word is set by software. From these the bank drives a level interrupt request to the core. The core index is a parameter, and the identity register holds it from reset onward.

Register indices, which an instruction decoder relies on: 0 status, 1 saved status (exception), 2 saved status (break), 3 interrupt enable, 4 interrupt pending, 5 core identity, 7 exception cause, 8 page-table address, 9 translation access, 10 translation control, 12 faulting address. Indices 6, 11, 13, 14 and 15 are always reserved.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset every register reads zero, with two exceptions. Status reads 0x0080_0000, which is only the register-set-interrupt-enable bit (bit 23) set. The identity register (index 5) reads the CORE_ID parameter.
- R2: A write to index i stores (wdata & W[i]) | (old & RO[i]). It takes effect at the next rising clock edge.
- R3: A register whose masks are both zero reads 0 and is unchanged by any write. The reserved indices are 6, 11 and 13 to 15, plus 3 and 4 with external interrupts, plus 8 to 10 without virtual memory.
- R4: Without external interrupts, status W is bit 0 (global interrupt enable), plus bits 1 and 2 when virtual memory is present, and status RO is bit 23. Enable (index 3) has W = 0xFFFF_FFFF.
- R5: With external interrupts, status W covers bit 0, the handler-level bits 3 to 9, the previous-set bits 16 to 21 and bit 23, plus bits 1 and 2 when virtual memory is present. Status RO covers the current-set bits 10 to 15 and the non-maskable flag at bit 22.
- R6: Indices 1, 2 and 12 are fully writable. Indices 5 and 7 are fully read-only and never change after reset.
- R7: Without external interrupts, pending bit k equals the level of irq_lines_i[k] sampled at the previous rising edge. Writes to index 4 have no effect.
- R8: irq_req_o is high exactly when status bit 0 is set and (pending & enable) is nonzero. It is always low with external interrupts.
- R9: With virtual memory, index 8 has W = 0xFFFF_FFFC. Index 9 has W = 0xFFFF_FFFF. Index 10 has W = 0x00FF_FFF0 and RO = 0x0000_000F.
- R10: rdata_o shows the register selected by idx_i in the same cycle, with no clock edge between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for the selected register |
| idx_i | input | 4 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| irq_lines_i | input | 32 | Interrupt input levels |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The bench drives two builds side by side. One has internal interrupts and virtual memory; the other has external interrupts and no virtual memory. It writes all-ones and all-zeros to every index in both builds. A swapped or missing mask would then leak bits into reserved positions, would let the identity or cause register change, or would let status bit 23 drop in the internal-interrupt build. Writes to the pending word are mixed with changing interrupt levels, so a bank that stored pending writes, or that failed to copy the lines, shows a wrong pending value or a false request. The request is also checked with the global enable cleared while sources are active.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int unsigned CR_W   = 32;
  localparam int unsigned CR_N   = 16;
  localparam int unsigned IDX_W  = $clog2(CR_N);

  localparam int unsigned IX_STATUS  = 0;
  localparam int unsigned IX_ESTAT   = 1;
  localparam int unsigned IX_BSTAT   = 2;
  localparam int unsigned IX_IEN     = 3;
  localparam int unsigned IX_IPEND   = 4;
  localparam int unsigned IX_ID      = 5;
  localparam int unsigned IX_CAUSE   = 7;
  localparam int unsigned IX_PTADDR  = 8;
  localparam int unsigned IX_XLACC   = 9;
  localparam int unsigned IX_XLCTL   = 10;
  localparam int unsigned IX_FAULT   = 12;

  // status field masks
  localparam logic [CR_W-1:0] ST_GIE   = 32'h0000_0001;
  localparam logic [CR_W-1:0] ST_USER  = 32'h0000_0002;
  localparam logic [CR_W-1:0] ST_XEN   = 32'h0000_0004;
  localparam logic [CR_W-1:0] ST_HNMI  = 32'h0000_0008;
  localparam logic [CR_W-1:0] ST_HLVL  = 32'h0000_03F0;
  localparam logic [CR_W-1:0] ST_CSET  = 32'h0000_FC00;
  localparam logic [CR_W-1:0] ST_PSET  = 32'h003F_0000;
  localparam logic [CR_W-1:0] ST_NMIF  = 32'h0040_0000;
  localparam logic [CR_W-1:0] ST_SETIE = 32'h0080_0000;

  localparam logic [CR_W-1:0] ALL1 = '1;

  function automatic logic [CR_W-1:0] wr_mask(int unsigned idx, bit ext_irq, bit vmem);
    logic [CR_W-1:0] m;
    m = '0;
    case (idx)
      IX_STATUS: begin
        m = ST_GIE;
        if (ext_irq) m = m | ST_SETIE | ST_PSET | ST_HLVL | ST_HNMI;
        if (vmem)    m = m | ST_USER | ST_XEN;
      end
      IX_ESTAT, IX_BSTAT, IX_FAULT: m = ALL1;
      IX_IEN:    m = ext_irq ? '0 : ALL1;
      IX_PTADDR: m = vmem ? 32'hFFFF_FFFC : '0;
      IX_XLACC:  m = vmem ? ALL1 : '0;
      IX_XLCTL:  m = vmem ? 32'h00FF_FFF0 : '0;
      default:   m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [CR_W-1:0] ro_mask(int unsigned idx, bit ext_irq, bit vmem);
    logic [CR_W-1:0] m;
    m = '0;
    case (idx)
      IX_STATUS: m = ext_irq ? (ST_NMIF | ST_CSET) : ST_SETIE;
      IX_ID, IX_CAUSE: m = ALL1;
      IX_IPEND:  m = ext_irq ? '0 : ALL1;
      IX_XLCTL:  m = vmem ? 32'h0000_000F : '0;
      default:   m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [CR_W-1:0] rst_value(int unsigned idx, logic [CR_W-1:0] core_id);
    logic [CR_W-1:0] v;
    v = '0;
    if (idx == IX_STATUS) v = ST_SETIE;
    if (idx == IX_ID)     v = core_id;
    return v;
  endfunction
endpackage

// File: rtl/ctlreg_rst_sync.sv
module ctlreg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ctlreg_merge.sv
module ctlreg_merge
  import ctlreg_pkg::*;
#(
  parameter logic [CR_W-1:0] WMASK  = '0,
  parameter logic [CR_W-1:0] RMASK  = '0,
  parameter logic [CR_W-1:0] RSTVAL = '0,
  parameter bit              HW_LD  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CR_W-1:0] wdata,
  input  logic [CR_W-1:0] hw_data,
  output logic [CR_W-1:0] q
);
  localparam logic [CR_W-1:0] KEEP = WMASK | RMASK;

  logic [CR_W-1:0] q_r;
  logic [CR_W-1:0] q_nxt;
  logic            q_en;

  always_comb begin
    q_en  = we | HW_LD;
    q_nxt = q_r;
    if (HW_LD)   q_nxt = hw_data & RMASK;
    else if (we) q_nxt = (wdata & WMASK) | (q_r & RMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= RSTVAL & KEEP;
    else if (q_en) q_r <= q_nxt;
  end

  assign q = q_r & KEEP;
endmodule

// File: rtl/ctlreg_irqgen.sv
module ctlreg_irqgen
  import ctlreg_pkg::*;
#(
  parameter bit EXT_IRQ = 1'b0
) (
  input  logic            gie,
  input  logic [CR_W-1:0] pend,
  input  logic [CR_W-1:0] enab,
  output logic            req
);
  logic live;

  always_comb begin
    live = |(pend & enab);
    req  = !EXT_IRQ && gie && live;
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter bit               EXT_IRQ = 1'b0,
  parameter bit               HAS_MMU = 1'b1,
  parameter logic [CR_W-1:0]  CORE_ID = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CR_W-1:0]  wdata_i,
  output logic [CR_W-1:0]  rdata_o,
  input  logic [CR_W-1:0]  irq_lines_i,
  output logic             irq_req_o
);
  logic                       rst_sync_n;
  logic [CR_N-1:0][CR_W-1:0]  reg_q;
  logic [CR_N-1:0]            reg_we;

  ctlreg_rst_sync #(.STAGES(2)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    reg_we = '0;
    reg_we[idx_i] = wr_en_i;
  end

  for (genvar gi = 0; gi < CR_N; gi++) begin : g_reg
    ctlreg_merge #(
      .WMASK  (wr_mask(gi, EXT_IRQ, HAS_MMU)),
      .RMASK  (ro_mask(gi, EXT_IRQ, HAS_MMU)),
      .RSTVAL (rst_value(gi, CORE_ID)),
      .HW_LD  (gi == IX_IPEND)
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .we      (reg_we[gi]),
      .wdata   (wdata_i),
      .hw_data (irq_lines_i),
      .q       (reg_q[gi])
    );
  end

  assign rdata_o = reg_q[idx_i];

  ctlreg_irqgen #(.EXT_IRQ(EXT_IRQ)) u_irq (
    .gie  (reg_q[IX_STATUS][0]),
    .pend (reg_q[IX_IPEND]),
    .enab (reg_q[IX_IEN]),
    .req  (irq_req_o)
  );
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk
  import ctlreg_pkg::*;
#(
  parameter bit              EXT_IRQ = 1'b0,
  parameter bit              HAS_MMU = 1'b1,
  parameter logic [CR_W-1:0] CORE_ID = '0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en_i,
  input logic [IDX_W-1:0]          idx_i,
  input logic [CR_W-1:0]           wdata_i,
  input logic [CR_W-1:0]           rdata_o,
  input logic [CR_W-1:0]           irq_lines_i,
  input logic                      irq_req_o,
  input logic [CR_N-1:0][CR_W-1:0] reg_q
);
  logic idx_rsvd;
  always_comb begin
    idx_rsvd = (idx_i == 4'd6) || (idx_i == 4'd11) || (idx_i >= 4'd13) ||
               (EXT_IRQ && (idx_i == 4'd3 || idx_i == 4'd4)) ||
               (!HAS_MMU && (idx_i >= 4'd8) && (idx_i <= 4'd10));
  end

  a_r3_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rsvd |-> rdata_o == '0);

  a_r6_full_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i == 4'd1) |=> reg_q[1] == $past(wdata_i));

  a_r6_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i == 4'd5) |=> $stable(reg_q[5]));

  a_r7_pend_follows_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !EXT_IRQ |=> reg_q[4] == $past(irq_lines_i));

  a_r4_setie_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !EXT_IRQ |-> reg_q[0][23]);

  a_r8_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> reg_q[0][0]);

  a_r8_req_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (reg_q[3] & reg_q[4]) != '0);
endmodule

bind ctlreg_bank ctlreg_bank_chk #(
  .EXT_IRQ (EXT_IRQ),
  .HAS_MMU (HAS_MMU),
  .CORE_ID (CORE_ID)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en_i     (wr_en_i),
  .idx_i       (idx_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_lines_i (irq_lines_i),
  .irq_req_o   (irq_req_o),
  .reg_q       (reg_q)
);

// File: tb/tb_ctlreg_bank.sv
module tb_ctlreg_bank;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  idx;
  logic [31:0] wdata;
  logic [31:0] irq;
  logic [31:0] rd0, rd1;
  logic        req0, req1;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m0 [16];
  logic [31:0] m1 [16];

  localparam logic [31:0] ID0 = 32'h0000_0005;
  localparam logic [31:0] ID1 = 32'h0000_002A;

  ctlreg_bank #(.EXT_IRQ(1'b0), .HAS_MMU(1'b1), .CORE_ID(ID0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx), .wdata_i(wdata),
    .rdata_o(rd0), .irq_lines_i(irq), .irq_req_o(req0));

  ctlreg_bank #(.EXT_IRQ(1'b1), .HAS_MMU(1'b0), .CORE_ID(ID1)) dut_eic (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx), .wdata_i(wdata),
    .rdata_o(rd1), .irq_lines_i(irq), .irq_req_o(req1));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] wm(int i, bit ext, bit mmu);
    case (i)
      0: return ext ? (mmu ? 32'h00BF_03FF : 32'h00BF_03F9) : (mmu ? 32'h7 : 32'h1);
      1, 2, 12: return 32'hFFFF_FFFF;
      3: return ext ? 32'h0 : 32'hFFFF_FFFF;
      8: return mmu ? 32'hFFFF_FFFC : 32'h0;
      9: return mmu ? 32'hFFFF_FFFF : 32'h0;
      10: return mmu ? 32'h00FF_FFF0 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] rm(int i, bit ext, bit mmu);
    case (i)
      0: return ext ? 32'h0040_FC00 : 32'h0080_0000;
      4: return ext ? 32'h0 : 32'hFFFF_FFFF;
      5, 7: return 32'hFFFF_FFFF;
      10: return mmu ? 32'h0000_000F : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagof(int i, bit ext, bit mmu);
    if ((wm(i, ext, mmu) | rm(i, ext, mmu)) == 32'h0) return "R3";
    if (i == 0) return ext ? "R5" : "R4";
    if (i == 3) return "R4";
    if (i == 4) return "R7";
    if (i >= 8 && i <= 10) return "R9";
    return "R6";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", req, idx, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m0[i] = (i == 0) ? 32'h0080_0000 : (i == 5) ? ID0 : 32'h0;
      m1[i] = (i == 0) ? 32'h0080_0000 : (i == 5) ? ID1 : 32'h0;
    end
  endtask

  // drive one cycle, check reads against the model, then advance the model
  task automatic step(bit w, int i, logic [31:0] d, logic [31:0] lines, string tag);
    string t0, t1;
    logic  e0;
    @(negedge clk);
    wr_en = w; idx = i[3:0]; wdata = d; irq = lines;
    #1;
    t0 = (tag == "") ? tagof(i, 0, 1) : tag;
    t1 = (tag == "") ? tagof(i, 1, 0) : tag;
    chk(t0, rd0, m0[i]);
    chk(t1, rd1, m1[i]);
    e0 = m0[0][0] && ((m0[3] & m0[4]) != 32'h0);
    chk("R8", {31'h0, req0}, {31'h0, e0});
    chk("R8", {31'h0, req1}, 32'h0);
    if (w) begin
      m0[i] = (d & wm(i, 0, 1)) | (m0[i] & rm(i, 0, 1));
      m1[i] = (d & wm(i, 1, 0)) | (m1[i] & rm(i, 1, 0));
    end
    m0[4] = lines;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; idx = '0; wdata = '0; irq = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values, no writes, lines low
    for (int i = 0; i < 16; i++) step(0, i, 32'h0, 32'h0, "R1");

    // R2: all-ones then all-zeros merge over every index
    for (int i = 0; i < 16; i++) step(1, i, 32'hFFFF_FFFF, 32'h0, "R2");
    for (int i = 0; i < 16; i++) step(0, i, 32'h0, 32'h0, "");
    for (int i = 0; i < 16; i++) step(1, i, 32'h0, 32'h0, "R2");
    for (int i = 0; i < 16; i++) step(0, i, 32'h0, 32'h0, "");

    // R7/R8: pending ignores writes, request gated by enable and GIE
    step(1, 3, 32'h0000_0100, 32'h0, "");
    step(1, 0, 32'h0000_0001, 32'h0, "");
    step(1, 4, 32'hFFFF_FFFF, 32'h0, "");
    step(0, 4, 32'h0, 32'h0000_0100, "R7");
    step(0, 4, 32'h0, 32'h0000_0200, "R7");
    step(0, 4, 32'h0, 32'h0000_0100, "R7");
    step(1, 0, 32'h0, 32'h0000_0100, "");
    step(0, 0, 32'h0, 32'h0000_0100, "R8");
    step(1, 0, 32'h1, 32'h0000_0100, "");
    step(0, 4, 32'h0, 32'h0, "R8");

    // R10: index changes every cycle
    for (int i = 0; i < 32; i++) step(0, (i * 7) % 16, 32'h0, 32'h0000_0100, "R10");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      automatic int          ri = $urandom % 16;
      automatic bit          rw = ($urandom % 3) != 0;
      automatic logic [31:0] rd = $urandom;
      automatic logic [31:0] rl = (($urandom % 4) == 0) ? $urandom : (32'h1 << ($urandom % 32));
      step(rw, ri, rd, rl, "");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule